// File: doc/BRIEF.md
# 66-bit Block Receive Sink

This block sits behind a receive PCS whose MAC has been bypassed. On some cycles it receives a wide beat that packs several 64b/66b blocks side by side. It unpacks each accepted beat into single 66-bit blocks and hands them to a narrow consumer one block per handshake. Each output block carries its 2-bit sync header, its 64-bit payload, a marker flag and a header-error flag.

The input side cannot be stalled. A beat is therefore written into a small beat FIFO on every cycle in which the input is valid. A static mode input decides what happens to beats flagged as alignment markers:

- In marker-drop mode (`otn_mode_i = 0`) the beat holds no usable data and is thrown away.
- In marker-pass mode (`otn_mode_i = 1`) the beat holds the received markers. It is queued like any other beat, and its blocks are tagged with the marker flag.

The `LANES` parameter sets the number of blocks per beat (1, 2, 4, 8 or 16). `DEPTH` sets the number of beats the FIFO holds, a power of two of at least 2. Reset is asynchronous and active-low.

Top module: `blk66_rx_sink`

## Requirements
- R1: While reset is asserted, and after it is released with no input, `out_valid_o` is 0 and `overflow_o` is 0. Reset empties the FIFO and restarts the lane position at lane 0.
- R2: Within a beat, block k occupies `in_data_i[66*k+65 : 66*k]`. Lane 0 is emitted first and lanes follow in ascending order. Beats leave in the order they were accepted.
- R3: For each emitted block, `out_hdr_o` equals bits [1:0] of the 66-bit block and `out_payload_o` equals bits [65:2].
- R4: When `in_valid_i` is 0, `in_data_i` and `in_marker_i` are ignored and no block is produced from them.
- R5: With `otn_mode_i = 0`, a beat with `in_valid_i = 1` and `in_marker_i = 1` is discarded and produces no output block.
- R6: With `otn_mode_i = 1`, a marker beat is emitted in full with `out_marker_o = 1` on each of its blocks. Blocks of non-marker beats carry `out_marker_o = 0` in both modes.
- R7: `out_hdr_err_o` is 1 when `out_hdr_o` is 2'b00 or 2'b11, and 0 when it is 2'b01 or 2'b10.
- R8: While `out_valid_o = 1` and `out_ready_i = 0`, the next cycle keeps `out_valid_o = 1`, and the header, payload and flags stay unchanged.
- R9: A valid beat is accepted whenever the FIFO has space. The FIFO also has space when its head beat leaves in the same cycle. A beat that must be kept and arrives with the FIFO full and no head leaving is dropped. That event sets `overflow_o`, which stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| otn_mode_i | input | 1 | Static mode: 1 passes marker beats with a flag, 0 drops them |
| in_valid_i | input | 1 | Input beat qualifier |
| in_marker_i | input | 1 | Beat holds alignment markers (meaningful only with `in_valid_i`) |
| in_data_i | input | 66*LANES | Packed 66-bit blocks, lane 0 in the low bits |
| out_valid_o | output | 1 | An output block is presented |
| out_ready_i | input | 1 | Consumer accepts the presented block |
| out_hdr_o | output | 2 | Sync header of the presented block |
| out_payload_o | output | 64 | Payload of the presented block |
| out_marker_o | output | 1 | Presented block comes from a marker beat |
| out_hdr_err_o | output | 1 | Presented sync header is 2'b00 or 2'b11 |
| overflow_o | output | 1 | Sticky: a beat was lost to a full FIFO |

## Verification
The bench builds each block from its beat and lane numbers, so every lane order and every one of the four header values appears. A design that unpacks lanes from the top, or takes the header from the high bits, fails on the first beat. Garbage data and stray marker pulses are driven while the input is idle. A design that does not qualify by valid would then emit extra blocks. It would also drop or flag the wrong beats in either mode.

A stalled consumer fills the FIFO exactly and then receives one beat more. A design that counts occupancy wrong would either overwrite a queued beat or raise `overflow_o` one beat early. A design whose flag is not sticky would clear `overflow_o` during the drain.

// File: rtl/blk66_pkg.sv
package blk66_pkg;

  localparam int BLK_W = 66;
  localparam int HDR_W = 2;
  localparam int PAY_W = BLK_W - HDR_W;

  // Payload occupies the upper bits, sync header the lowest two.
  typedef struct packed {
    logic [PAY_W-1:0] payload;
    logic [HDR_W-1:0] hdr;
  } blk66_t;

  function automatic logic hdr_bad(input logic [HDR_W-1:0] h);
    return (h == 2'b00) || (h == 2'b11);
  endfunction

endpackage

// File: rtl/blk66_beat_fifo.sv
module blk66_beat_fifo #(
  parameter int W     = 265,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] data_o,
  output logic         full_o,
  output logic         empty_o,
  output logic         drop_o
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int PW = AW + 1;

  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic          wr_en;
  logic [PW-1:0] occ;

  assign occ     = wr_q - rd_q;
  assign empty_o = (occ == '0);
  assign full_o  = (occ == PW'(DEPTH));

  // A write is allowed when space exists or the head leaves this cycle.
  always_comb begin
    wr_en  = push_i && (!full_o || pop_i);
    drop_o = push_i && full_o && !pop_i;
    wr_d   = wr_q;
    rd_d   = rd_q;
    if (wr_en)                wr_d = wr_q + PW'(1);
    if (pop_i && !empty_o)    rd_d = rd_q + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q <= '0;
      rd_q <= '0;
    end else begin
      wr_q <= wr_d;
      rd_q <= rd_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_q[AW-1:0]] <= data_i;
  end

  assign data_o = mem_q[rd_q[AW-1:0]];

  // R9: occupancy never exceeds the configured depth
  a_r9_occ_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= PW'(DEPTH));

  // R9: an accepted beat into an empty FIFO is visible next cycle
  a_r9_push_seen: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && empty_o) |=> !empty_o);

endmodule

// File: rtl/blk66_lane_ctr.sv
module blk66_lane_ctr #(
  parameter int LANES = 4
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   advance_i,
  output logic [((LANES > 1) ? $clog2(LANES) : 1)-1:0] lane_o,
  output logic                                   last_o
);

  localparam int LW = (LANES > 1) ? $clog2(LANES) : 1;

  generate
    if (LANES == 1) begin : g_single
      assign lane_o = '0;
      assign last_o = 1'b1;
    end else begin : g_multi
      logic [LW-1:0] cnt_q, cnt_d;

      assign last_o = (cnt_q == LW'(LANES - 1));
      assign lane_o = cnt_q;

      always_comb begin
        cnt_d = cnt_q;
        if (advance_i) cnt_d = last_o ? '0 : cnt_q + LW'(1);
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
      end

      // R2: lane position stays inside the beat
      a_r2_lane_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LW'(LANES - 1));

      // R2: lanes advance by one per accepted block
      a_r2_lane_step: assert property (@(posedge clk) disable iff (!rst_n)
        (advance_i && !last_o) |=> (cnt_q == $past(cnt_q) + LW'(1)));
    end
  endgenerate

endmodule

// File: rtl/blk66_lane_sel.sv
module blk66_lane_sel
  import blk66_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic [BLK_W*LANES-1:0]                       beat_i,
  input  logic [((LANES > 1) ? $clog2(LANES) : 1)-1:0] lane_i,
  output blk66_t                                       blk_o,
  output logic                                         hdr_err_o
);

  logic [BLK_W-1:0] lanes [LANES];

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_unpack
      assign lanes[g] = beat_i[g*BLK_W +: BLK_W];
    end
  endgenerate

  assign blk_o     = blk66_t'(lanes[lane_i]);
  assign hdr_err_o = hdr_bad(blk_o.hdr);

endmodule

// File: rtl/blk66_rx_sink.sv
module blk66_rx_sink
  import blk66_pkg::*;
#(
  parameter int LANES = 4,
  parameter int DEPTH = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   otn_mode_i,
  input  logic                   in_valid_i,
  input  logic                   in_marker_i,
  input  logic [66*LANES-1:0]    in_data_i,
  output logic                   out_valid_o,
  input  logic                   out_ready_i,
  output logic [1:0]             out_hdr_o,
  output logic [63:0]            out_payload_o,
  output logic                   out_marker_o,
  output logic                   out_hdr_err_o,
  output logic                   overflow_o
);

  localparam int BEAT_W = BLK_W * LANES;
  localparam int ENT_W  = BEAT_W + 1;
  localparam int LW     = (LANES > 1) ? $clog2(LANES) : 1;

  logic             keep;
  logic             fire;
  logic             pop;
  logic             fifo_full;
  logic             fifo_empty;
  logic             fifo_drop;
  logic [ENT_W-1:0] head;
  logic [LW-1:0]    lane;
  logic             lane_last;
  blk66_t           cur_blk;
  logic             cur_err;
  logic             ovf_q, ovf_d;

  // Marker beats survive only in pass mode; idle cycles are never stored.
  assign keep = in_valid_i && (otn_mode_i || !in_marker_i);

  assign out_valid_o = !fifo_empty;
  assign fire        = out_valid_o && out_ready_i;
  assign pop         = fire && lane_last;

  blk66_beat_fifo #(
    .W     (ENT_W),
    .DEPTH (DEPTH)
  ) fifo_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .push_i  (keep),
    .data_i  ({in_marker_i, in_data_i}),
    .pop_i   (pop),
    .data_o  (head),
    .full_o  (fifo_full),
    .empty_o (fifo_empty),
    .drop_o  (fifo_drop)
  );

  blk66_lane_ctr #(
    .LANES (LANES)
  ) lane_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .advance_i (fire),
    .lane_o    (lane),
    .last_o    (lane_last)
  );

  blk66_lane_sel #(
    .LANES (LANES)
  ) sel_i (
    .beat_i    (head[BEAT_W-1:0]),
    .lane_i    (lane),
    .blk_o     (cur_blk),
    .hdr_err_o (cur_err)
  );

  assign out_hdr_o     = cur_blk.hdr;
  assign out_payload_o = cur_blk.payload;
  assign out_marker_o  = head[BEAT_W];
  assign out_hdr_err_o = cur_err;

  always_comb begin
    ovf_d = ovf_q;
    if (fifo_drop) ovf_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovf_q <= 1'b0;
    else        ovf_q <= ovf_d;
  end

  assign overflow_o = ovf_q;

  // R8: a presented block waits unchanged for the consumer
  a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && !out_ready_i) |=>
      (out_valid_o && $stable(out_hdr_o) && $stable(out_payload_o)
       && $stable(out_marker_o) && $stable(out_hdr_err_o)));

  // R9: the overflow flag never clears outside reset
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_o |=> overflow_o);

  // R9: overflow rises only after a beat arrived
  a_r9_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow_o) |-> $past(in_valid_i));

  // R6: flagged blocks appear only in pass mode
  a_r6_flag_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && out_marker_o) |-> otn_mode_i);

  // R4: an idle input cannot create output from nothing
  a_r4_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid_i && !out_valid_o) |=> !out_valid_o);

endmodule

// File: tb/blk66_rx_sink_tb_top.sv
module blk66_rx_sink_tb_top;

  localparam int LANES = 4;
  localparam int DEPTH = 4;

  logic clk;
  logic rst_n;
  logic otn_mode;
  logic in_valid;
  logic in_marker;
  logic [66*LANES-1:0] in_data;
  logic out_valid;
  logic out_ready;
  logic [1:0]  out_hdr;
  logic [63:0] out_payload;
  logic out_marker;
  logic out_hdr_err;
  logic overflow;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  int rmode = 0;
  bit done = 0;
  logic [66:0] expq[$];

  bit          hold = 0;
  logic [68:0] held;

  blk66_rx_sink #(.LANES(LANES), .DEPTH(DEPTH)) dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .otn_mode_i    (otn_mode),
    .in_valid_i    (in_valid),
    .in_marker_i   (in_marker),
    .in_data_i     (in_data),
    .out_valid_o   (out_valid),
    .out_ready_i   (out_ready),
    .out_hdr_o     (out_hdr),
    .out_payload_o (out_payload),
    .out_marker_o  (out_marker),
    .out_hdr_err_o (out_hdr_err),
    .overflow_o    (overflow)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req,
                     input logic [68:0] act, input logic [68:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    end
  endtask

  function automatic logic [65:0] mk_blk(input int b, input int l);
    logic [1:0]  h;
    logic [63:0] p;
    h = 2'((b + l) & 3);
    p = {16'(b), 8'(l), 8'(b * 7 + l), 32'hC0DE0000 ^ 32'(b)};
    return {p, h};
  endfunction

  // Idle cycles carry junk data and a toggling marker (R4).
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      in_valid  = 1'b0;
      in_marker = 1'(i & 1);
      in_data   = {LANES{66'h2DEADBEEF0BADF00D}} ^ (66*LANES)'(i);
      @(negedge clk);
    end
  endtask

  task automatic beat(input int b, input bit mk);
    bit keep_it;
    keep_it   = !mk || otn_mode;
    in_valid  = 1'b1;
    in_marker = mk;
    for (int l = 0; l < LANES; l++) begin
      in_data[l*66 +: 66] = mk_blk(b, l);
      if (keep_it) expq.push_back({mk, mk_blk(b, l)});
    end
    @(negedge clk);
    in_valid  = 1'b0;
    in_marker = 1'b1;
  endtask

  // Consumer and output checker: acts at the falling edge.
  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      hold = 0;
    end else begin
      out_ready = (rmode == 0) ? 1'b1 : (rmode == 1) ? ((cyc % 3) != 0) : 1'b0;
      if (hold) begin
        chk(out_valid && {out_marker, out_hdr_err, out_payload, out_hdr} == held[67:0],
            "R8 held block changed", {out_valid, out_marker, out_hdr_err, out_payload, out_hdr},
            {1'b1, held[67:0]});
      end
      if (out_valid) begin
        held = {1'b1, out_marker, out_hdr_err, out_payload, out_hdr};
        if (out_ready) begin
          if (expq.size() == 0) begin
            chk(1'b0, "R4 R5 unexpected block", {3'b0, out_payload, out_hdr}, '0);
          end else begin
            logic [66:0] e;
            e = expq.pop_front();
            chk({out_payload, out_hdr} == e[65:0], "R2 R3 block order/split",
                {3'b0, out_payload, out_hdr}, {3'b0, e[65:0]});
            chk(out_marker == e[66], "R6 marker flag", 69'(out_marker), 69'(e[66]));
            chk(out_hdr_err == ((e[1:0] == 2'b00) || (e[1:0] == 2'b11)),
                "R7 header error flag", 69'(out_hdr_err),
                69'((e[1:0] == 2'b00) || (e[1:0] == 2'b11)));
          end
        end
        hold = !out_ready;
      end else begin
        hold = 0;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    rst_n     = 1'b0;
    otn_mode  = 1'b0;
    out_ready = 1'b1;
    in_valid  = 1'b0;
    in_marker = 1'b0;
    in_data   = '0;
    repeat (3) @(negedge clk);
    chk(!out_valid && !overflow, "R1 reset state", {67'b0, out_valid, overflow}, '0);
    rst_n = 1'b1;
    idle(4);
    chk(!out_valid && !overflow, "R1 idle after reset", {67'b0, out_valid, overflow}, '0);

    // Drop mode, consumer always ready; every third beat is a marker (R5).
    rmode = 0;
    for (int b = 0; b < 16; b++) begin
      beat(b, (b % 3) == 2);
      idle(4);
    end
    idle(10);
    chk(expq.size() == 0 && !out_valid, "R5 R4 drop mode drained",
        69'(expq.size()), '0);

    // Pass mode, throttled consumer; markers tagged (R6).
    otn_mode = 1'b1;
    rmode = 1;
    for (int b = 16; b < 32; b++) begin
      beat(b, (b % 4) == 1);
      idle(7);
    end
    idle(20);
    chk(expq.size() == 0 && !out_valid, "R6 pass mode drained",
        69'(expq.size()), '0);

    // Stalled consumer: fill exactly, then one beat too many (R9, R8).
    otn_mode = 1'b0;
    rmode = 2;
    idle(2);
    for (int b = 40; b < 40 + DEPTH; b++) beat(b, 1'b0);
    chk(!overflow, "R9 full without overflow", 69'(overflow), 69'(0));
    in_valid  = 1'b1;
    in_marker = 1'b0;
    for (int l = 0; l < LANES; l++) in_data[l*66 +: 66] = mk_blk(99, l);
    @(negedge clk);
    in_valid = 1'b0;
    chk(overflow, "R9 overflow on extra beat", 69'(overflow), 69'(1));
    idle(6);
    rmode = 0;
    idle(30);
    chk(expq.size() == 0 && !out_valid, "R9 queued beats intact",
        69'(expq.size()), '0);
    chk(overflow, "R9 overflow sticky", 69'(overflow), 69'(1));

    // Reset clears everything (R1).
    rmode = 2;
    beat(50, 1'b0);
    rst_n = 1'b0;
    #1;
    chk(!out_valid && !overflow, "R1 reset clears state",
        {67'b0, out_valid, overflow}, '0);
    expq.delete();
    @(negedge clk);
    rst_n = 1'b1;
    rmode = 0;
    idle(3);
    chk(!out_valid, "R1 fifo empty after reset", 69'(out_valid), '0);
    beat(60, 1'b0);
    idle(8);
    chk(expq.size() == 0, "R2 lane restart after reset", 69'(expq.size()), '0);

    summary();
    $finish;
  end

endmodule